// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block works out how fast the system clock runs compared with the audio sample rate. In slave mode the frame clock (word select) arrives from outside. The block counts system clock cycles from one rising word-select edge to the next. It sorts that count into one of four supported multiples of the sample rate: 256, 384, 512 or 768. A ratio is accepted only after two periods in a row agree. No configuration input is needed. Because the system clock is frequency-locked to the frame clocks, the count is exact and only a small tolerance is required.

In master mode the system clock must be 256 times the sample rate. The block then ignores its word-select input. It reports that fixed ratio and drives its own bit clock (system clock divided by 4) and word-select clock (one full period per 256 system clocks). A mode input selects slave (low) or master (high).

The control is a four-state machine. SEEK waits for the first rising edge. MEASURE times the first full period. TRACK compares each new period with the one before it. MASTER holds the fixed ratio. The transitions are:
- any state goes to MASTER when the mode input is high;
- MASTER goes to SEEK when the mode input falls;
- SEEK goes to MEASURE on a rising edge;
- MEASURE goes to TRACK on the next rising edge;
- TRACK stays in TRACK.

Top module: `audio_ratio_detect`

## Requirements
- R1: A synchronous active-high reset sets ratio_code to 0, ratio_valid low, and bck_out and ws_out low, and restarts the period measurement.
- R2: In slave mode a period of N system clocks maps to ratio_code 0 for N=256, 1 for N=384, 2 for N=512 and 3 for N=768, each within ±2 cycles. The code is reported once two consecutive periods are accepted.
- R3: A period is accepted only if it differs from the period just before it by 2 cycles or less. Alternating periods of 254 and 258 leave ratio_valid low. Alternating periods of 255 and 257 give code 0 with ratio_valid high.
- R4: A period that matches none of the four ratios drops ratio_valid and leaves ratio_code at its last accepted value.
- R5: With master_sel high, ratio_code is 0 (256) and ratio_valid is high from the cycle after master_sel is seen high, and ws_in has no effect.
- R6: In master mode bck_out has a period of 4 system clocks, high for 2 and low for 2.
- R7: In master mode ws_out toggles every 32 bit-clock periods (128 system clocks), always on the system clock edge where bck_out falls.
- R8: In slave mode bck_out and ws_out are held low. Leaving master mode drops ratio_valid until a new ratio is accepted.
- R9: After a change of slave ratio, the first period of the new rate drops ratio_valid, and the second such period makes the new code valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 0 = slave (detect ratio), 1 = master (generate frame clocks) |
| ws_in | input | 1 | Word-select input used in slave mode |
| ratio_code | output | 2 | Detected ratio: 0=256, 1=384, 2=512, 3=768 |
| ratio_valid | output | 1 | High while the reported ratio is confirmed |
| bck_out | output | 1 | Bit clock driven in master mode |
| ws_out | output | 1 | Word-select clock driven in master mode |

## Verification
The assertions assume that ws_in is synchronous to clk or passes through the input synchronizer cleanly. They also assume master_sel changes only between whole clock cycles and that reset lasts at least one edge. The stimulus changes every input just after a falling clock edge. It builds word-select frames from whole numbers of system clocks, with the high phase half of the period. It switches modes only after the ratio under test has settled, so that each expected value depends only on the periods delivered before it.

// File: rtl/acr_pkg.sv
package acr_pkg;

    typedef enum logic [1:0] {
        RATIO_256 = 2'd0,
        RATIO_384 = 2'd1,
        RATIO_512 = 2'd2,
        RATIO_768 = 2'd3
    } ratio_e;

    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_TRACK   = 2'd2,
        ST_MASTER  = 2'd3
    } det_state_e;

    localparam int BASE_RATIO = 256;
    localparam int NUM_RATIOS = 4;

    // Nominal word-select period, in system clocks, for a ratio code.
    function automatic int nominal_len(input logic [1:0] code);
        case (code)
            2'd0:    return BASE_RATIO;
            2'd1:    return (BASE_RATIO * 3) / 2;
            2'd2:    return BASE_RATIO * 2;
            default: return BASE_RATIO * 3;
        endcase
    endfunction

endpackage

// File: rtl/ws_period_meter.sv
module ws_period_meter #(
    parameter int CNT_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ws_in,
    output logic             rise,
    output logic [CNT_W-1:0] period
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SYNC_STAGES:0] shift_q;
    logic [CNT_W-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], ws_in};
        end
    end

    assign rise   = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    assign period = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: between edges the counter advances by one each cycle until saturated
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (!rise && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ratio_lock_fsm.sv
module ratio_lock_fsm
    import acr_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_sel,
    input  logic             rise,
    input  logic [CNT_W-1:0] period,
    output logic [1:0]       ratio_code,
    output logic             ratio_valid
);
    det_state_e       state_q, state_d;
    ratio_e           code_q, cls;
    logic             valid_q;
    logic [CNT_W-1:0] prev_q;
    logic             hit;
    logic             spread_ok;
    int               delta;

    always_comb begin
        hit = 1'b0;
        cls = RATIO_256;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if ((int'(period) + TOL >= nominal_len(2'(i))) &&
                (int'(period) <= nominal_len(2'(i)) + TOL)) begin
                hit = 1'b1;
                cls = ratio_e'(i);
            end
        end
        delta     = int'(period) - int'(prev_q);
        spread_ok = (delta <= TOL) && (delta >= -TOL);
    end

    always_comb begin
        state_d = state_q;
        if (master_sel) begin
            state_d = ST_MASTER;
        end else begin
            unique case (state_q)
                ST_SEEK:    if (rise) state_d = ST_MEASURE;
                ST_MEASURE: if (rise) state_d = ST_TRACK;
                ST_TRACK:   state_d = ST_TRACK;
                ST_MASTER:  state_d = ST_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEEK;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= RATIO_256;
            valid_q <= 1'b0;
            prev_q  <= '0;
        end else if (master_sel) begin
            code_q  <= RATIO_256;
            valid_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_SEEK:    valid_q <= 1'b0;
                ST_MEASURE: if (rise) prev_q <= period;
                ST_TRACK: begin
                    if (rise) begin
                        prev_q <= period;
                        if (hit && spread_ok) begin
                            code_q  <= cls;
                            valid_q <= 1'b1;
                        end else begin
                            valid_q <= 1'b0;
                        end
                    end
                end
                ST_MASTER:  valid_q <= 1'b0;
            endcase
        end
    end

    assign ratio_code  = code_q;
    assign ratio_valid = valid_q;

    // R4: unmatched period drops the flag and keeps the code
    a_r4_miss_keeps_code: assert property (@(posedge clk) disable iff (rst)
        (!master_sel && state_q == ST_TRACK && rise && !hit)
        |=> (!ratio_valid && $stable(ratio_code)));

    // R3: a spread above the tolerance never validates
    a_r3_reject_spread: assert property (@(posedge clk) disable iff (rst)
        (!master_sel && state_q == ST_TRACK && rise && !spread_ok) |=> !ratio_valid);

    // R5: master mode reports the fixed ratio
    a_r5_master_fixed: assert property (@(posedge clk) disable iff (rst)
        ($past(master_sel) && !$past(rst)) |-> (ratio_valid && ratio_code == 2'd0));

    // R8: leaving master mode clears the flag
    a_r8_leave_master: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MASTER && !master_sel) |=> !ratio_valid);

endmodule

// File: rtl/frame_clk_gen.sv
module frame_clk_gen #(
    parameter int BCK_DIV       = 4,
    parameter int BITS_PER_HALF = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic bck_o,
    output logic ws_o
);
    localparam int DIV_W  = $clog2(BCK_DIV);
    localparam int BIT_W  = $clog2(BITS_PER_HALF);
    localparam int HALF   = BCK_DIV / 2;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_HALF - 1);

    logic [DIV_W-1:0] div_q, div_d;
    logic [BIT_W-1:0] bit_q;
    logic             bck_q, ws_q;

    assign div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
            bit_q <= '0;
            bck_q <= 1'b0;
            ws_q  <= 1'b0;
        end else begin
            div_q <= div_d;
            bck_q <= (int'(div_d) >= HALF);
            if (div_q == DIV_LAST) begin
                bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
                if (bit_q == BIT_LAST) ws_q <= ~ws_q;
            end
        end
    end

    assign bck_o = bck_q;
    assign ws_o  = ws_q;

    // R7: word select moves only together with a bit-clock falling edge
    a_r7_ws_on_bck_fall: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && ws_o != $past(ws_o)) |-> $fell(bck_o));

    // R6: a bit-clock high phase lasts more than one cycle
    a_r6_bck_high_hold: assert property (@(posedge clk) disable iff (rst)
        (en && $rose(bck_o)) |=> (bck_o || !en));

endmodule

// File: rtl/audio_ratio_detect.sv
module audio_ratio_detect #(
    parameter int CNT_W         = 11,
    parameter int TOL           = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int BCK_DIV       = 4,
    parameter int BITS_PER_HALF = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       master_sel,
    input  logic       ws_in,
    output logic [1:0] ratio_code,
    output logic       ratio_valid,
    output logic       bck_out,
    output logic       ws_out
);
    logic             rise;
    logic [CNT_W-1:0] period;

    ws_period_meter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .ws_in  (ws_in),
        .rise   (rise),
        .period (period)
    );

    ratio_lock_fsm #(.CNT_W(CNT_W), .TOL(TOL)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .master_sel  (master_sel),
        .rise        (rise),
        .period      (period),
        .ratio_code  (ratio_code),
        .ratio_valid (ratio_valid)
    );

    frame_clk_gen #(.BCK_DIV(BCK_DIV), .BITS_PER_HALF(BITS_PER_HALF)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .en    (master_sel),
        .bck_o (bck_out),
        .ws_o  (ws_out)
    );

    // R8: frame clock outputs stay low in slave mode
    a_r8_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(master_sel) |-> (!bck_out && !ws_out));

endmodule

// File: tb/test_audio_ratio_detect.sv
module test_audio_ratio_detect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_sel = 1'b0;
    logic       ws_in = 1'b0;
    logic [1:0] ratio_code;
    logic       ratio_valid;
    logic       bck_out;
    logic       ws_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [1:0] code;
        logic       valid;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    audio_ratio_detect i_audio_ratio_detect (
        .clk(clk), .rst(rst), .master_sel(master_sel), .ws_in(ws_in),
        .ratio_code(ratio_code), .ratio_valid(ratio_valid),
        .bck_out(bck_out), .ws_out(ws_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frames(input int len, input int n);
        for (int f = 0; f < n; f++) begin
            ws_in = 1'b1;
            repeat (len / 2) @(negedge clk);
            ws_in = 1'b0;
            repeat (len - len / 2) @(negedge clk);
        end
    endtask

    task automatic expect_out(input logic [1:0] code, input logic valid, input string tag);
        exp_t e;
        e.code = code; e.valid = valid; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // monitor: compares design outputs with queued expectations
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            e = sb_q[0];
            check({e.tag, " code"}, int'(ratio_code), int'(e.code));
            check({e.tag, " valid"}, int'(ratio_valid), int'(e.valid));
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int last_rise, hi_len, lo_len, ws_gap, last_ws_chg;
        logic prev_bck, prev_ws;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_out(2'd0, 1'b0, "R1 reset");
        check("R1 bck low", int'(bck_out), 0);
        check("R1 ws low", int'(ws_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 each ratio
        frames(256, 5);  expect_out(2'd0, 1'b1, "R2 ratio 256");
        frames(384, 5);  expect_out(2'd1, 1'b1, "R2 ratio 384");
        frames(512, 5);  expect_out(2'd2, 1'b1, "R2 ratio 512");
        frames(768, 5);  expect_out(2'd3, 1'b1, "R2 ratio 768");
        frames(770, 4);  expect_out(2'd3, 1'b1, "R2 ratio 768 plus 2");

        // R9 change of rate: one new period drops, second relocks
        frames(384, 1);  expect_out(2'd3, 1'b1, "R9 before new edge");
        frames(384, 1);  expect_out(2'd3, 1'b0, "R9 first new period");
        frames(384, 1);  expect_out(2'd1, 1'b1, "R9 second new period");

        // R4 unmatched period keeps last code
        frames(300, 4);  expect_out(2'd1, 1'b0, "R4 unmatched 300");
        frames(1000, 3); expect_out(2'd1, 1'b0, "R4 unmatched 1000");

        // R3 tolerance between consecutive periods
        frames(256, 5);  expect_out(2'd0, 1'b1, "R3 baseline");
        for (int k = 0; k < 3; k++) begin frames(254, 1); frames(258, 1); end
        expect_out(2'd0, 1'b0, "R3 spread 4 rejected");
        for (int k = 0; k < 3; k++) begin frames(255, 1); frames(257, 1); end
        expect_out(2'd0, 1'b1, "R3 spread 2 accepted");

        // R1 reset while locked
        frames(512, 5);
        expect_out(2'd2, 1'b1, "R1 locked before reset");
        rst = 1'b1; @(negedge clk); @(negedge clk);
        expect_out(2'd0, 1'b0, "R1 reset clears lock");
        rst = 1'b0; @(negedge clk);
        frames(768, 5);  expect_out(2'd3, 1'b1, "R2 lock after reset");

        // R5 master mode with ws_in toggling
        master_sel = 1'b1;
        @(negedge clk);
        expect_out(2'd0, 1'b1, "R5 master fixed ratio");
        frames(384, 4);
        expect_out(2'd0, 1'b1, "R5 ws_in ignored");

        // R6 / R7 measure master clocks
        prev_bck = bck_out; prev_ws = ws_out;
        last_rise = -1; hi_len = 0; lo_len = 0; last_ws_chg = -1; ws_gap = 0;
        for (int c = 0; c < 1200; c++) begin
            @(negedge clk);
            if (bck_out) hi_len++; else lo_len++;
            if (bck_out && !prev_bck) begin
                if (last_rise >= 0) check("R6 bck period", c - last_rise, 4);
                last_rise = c;
            end
            if (!bck_out && prev_bck && c > 8) check("R6 bck high phase", hi_len, 2);
            if (bck_out && !prev_bck && c > 8) check("R6 bck low phase", lo_len, 2);
            if (bck_out != prev_bck) begin
                if (bck_out) lo_len = 0; else hi_len = 0;
            end
            if (ws_out != prev_ws) begin
                check("R7 ws on bck fall", int'(prev_bck && !bck_out), 1);
                if (last_ws_chg >= 0) check("R7 ws half period", c - last_ws_chg, 128);
                last_ws_chg = c;
                ws_gap++;
            end
            prev_bck = bck_out; prev_ws = ws_out;
        end
        check("R7 ws toggled", int'(ws_gap >= 8), 1);

        // R8 back to slave: clocks low, flag dropped
        master_sel = 1'b0;
        @(negedge clk); @(negedge clk);
        expect_out(2'd0, 1'b0, "R8 left master");
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (bck_out || ws_out) begin
                check("R8 slave clocks low", int'(bck_out | ws_out), 0);
                break;
            end
        end
        check("R8 slave clocks low end", int'(bck_out | ws_out), 0);
        frames(512, 5);  expect_out(2'd2, 1'b1, "R8 relock after master");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule